// File: doc/BRIEF.md
# Dual-Core Mailbox Queue Pair

This block passes 32-bit words between two processor cores through two small one-way queues. Each core has its own register port. A write to the push address of a port places a word in the queue toward the other core. A read of the pop address of that port takes the oldest word from the queue toward itself. Each port also has a status address. Reading it returns four bits:

- bit 0: valid, set while the incoming queue holds data.
- bit 1: ready, set while the outgoing queue has room.
- bit 2: overflow, a sticky flag for a push attempted on a full queue.
- bit 3: underflow, a sticky flag for a pop attempted on an empty queue.

Each port has an interrupt output. It is high while that core's incoming queue holds data or either of its sticky flags is set. A core services the interrupt in two steps: it reads the pop address, then it writes the status address. Any value written to the status address clears both sticky flags of that port.

Each port decodes its access in the cycle of the strobe into one of six named kinds:

- ACC_IDLE: no strobe.
- ACC_STAT_RD: status read.
- ACC_STAT_CLR: status write.
- ACC_PUSH: write of the push address.
- ACC_POP: read of the pop address.
- ACC_UNMAPPED: any other address or direction.

The sticky pair is the state of the port. It moves on four transitions:

- PUSH while the outgoing queue is full sets overflow.
- POP while the incoming queue is empty sets underflow.
- STAT_CLR clears both flags.
- Every other access kind holds both flags.

Read data is registered. It appears on the data output in the cycle after the strobe and is zero in every other cycle.

Top module: `mbox_fifo_pair`

## Requirements
- R1: After reset, every status read returns 0x0000_0002 (ready only), both interrupts are low and both read-data outputs are zero.
- R2: A port write to offset 0x54 appends the word to the queue toward the other port. From the next cycle, the other port's status bit 0 reads 1.
- R3: A port read of offset 0x58 returns the head of its incoming queue in first-in first-out order, on the read-data output one cycle after the strobe, and removes that word.
- R4: A status read at offset 0x50 returns {28'b0, underflow, overflow, outgoing-not-full, incoming-not-empty}. The value reflects the state before the strobe edge.
- R5: Each queue holds 8 words. A push while the queue holds 8 words is dropped, clears nothing and sets status bit 2 of the pushing port. Bit 1 reads 0 while the queue is full.
- R6: A pop from an empty queue returns zero, leaves the queue unchanged and sets status bit 3 of the popping port.
- R7: A write of any value to offset 0x50 clears bits 2 and 3 of that port only. Bits 0 and 1 are unaffected.
- R8: A port's interrupt is high exactly while its incoming queue is non-empty or its bit 2 or bit 3 is set.
- R9: The flags of one port are independent of the other port's errors.
- R10: A read of an unmapped address returns zero. A write to an unmapped address changes no state.
- R11: A push and a pop on the same queue in the same cycle both take effect when the queue is neither full nor empty. A push to a full queue is dropped even when a pop happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sel | input | 1 | Core A access strobe |
| a_wr | input | 1 | Core A write (1) or read (0) |
| a_addr | input | 8 | Core A register offset |
| a_wdata | input | 32 | Core A write data |
| a_rdata | output | 32 | Core A read data, one cycle after the strobe |
| a_irq | output | 1 | Core A interrupt |
| b_sel | input | 1 | Core B access strobe |
| b_wr | input | 1 | Core B write (1) or read (0) |
| b_addr | input | 8 | Core B register offset |
| b_wdata | input | 32 | Core B write data |
| b_rdata | output | 32 | Core B read data, one cycle after the strobe |
| b_irq | output | 1 | Core B interrupt |

## Verification
The hardest situation to reach is a push into a full queue that lands in the same cycle as a pop of that queue by the other core. The bench first fills the queue with eight pushes. It then strobes both ports on one clock edge, one pushing and one popping. It drains the queue afterwards to show that the extra word never entered, and reads the pusher's status to see the overflow flag. Simultaneous push and pop on a partly filled queue is reached the same way, with one word preloaded.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_STAT_RD,
        ACC_STAT_CLR,
        ACC_PUSH,
        ACC_POP,
        ACC_UNMAPPED
    } acc_e;

    typedef struct packed {
        logic udf;
        logic ovf;
        logic ready;
        logic valid;
    } stat_t;

endpackage

// File: rtl/mbox_queue.sv
module mbox_queue #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push;
    logic             do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R5
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);

    // R11
    both_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full && !empty) |=> $stable(count));

endmodule

// File: rtl/mbox_port.sv
module mbox_port
    import mbox_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [7:0]      STAT_OFS = 8'h50,
    parameter logic [7:0]      PUSH_OFS = 8'h54,
    parameter logic [7:0]      POP_OFS  = 8'h58
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] in_head,
    input  logic              in_empty,
    input  logic              out_full,
    output logic              push,
    output logic [WORD_W-1:0] push_data,
    output logic              pop,
    output logic [WORD_W-1:0] rdata,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] A_PUSH = ADDR_W'(PUSH_OFS);
    localparam logic [ADDR_W-1:0] A_POP  = ADDR_W'(POP_OFS);

    acc_e  acc;
    logic  ovf_q, udf_q;
    logic  ovf_d, udf_d;
    stat_t stat;

    always_comb begin
        acc = ACC_IDLE;
        if (sel) begin
            if (addr == A_STAT)               acc = wr ? ACC_STAT_CLR : ACC_STAT_RD;
            else if (addr == A_PUSH && wr)    acc = ACC_PUSH;
            else if (addr == A_POP && !wr)    acc = ACC_POP;
            else                              acc = ACC_UNMAPPED;
        end
    end

    always_comb begin
        ovf_d = ovf_q;
        udf_d = udf_q;
        unique case (acc)
            ACC_STAT_CLR: begin
                ovf_d = 1'b0;
                udf_d = 1'b0;
            end
            ACC_PUSH:     ovf_d = ovf_q | out_full;
            ACC_POP:      udf_d = udf_q | in_empty;
            ACC_IDLE, ACC_STAT_RD, ACC_UNMAPPED: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else begin
            ovf_q <= ovf_d;
            udf_q <= udf_d;
        end
    end

    assign stat.udf   = udf_q;
    assign stat.ovf   = ovf_q;
    assign stat.ready = !out_full;
    assign stat.valid = !in_empty;

    assign push      = (acc == ACC_PUSH);
    assign push_data = wdata;
    assign pop       = (acc == ACC_POP) && !in_empty;
    assign irq       = !in_empty || ovf_q || udf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            unique case (acc)
                ACC_STAT_RD: rdata <= {{(WORD_W-4){1'b0}}, stat};
                ACC_POP:     rdata <= in_empty ? '0 : in_head;
                default:     rdata <= '0;
            endcase
        end
    end

    // R6
    udf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(udf_q) |-> $past(acc == ACC_POP && in_empty));

    // R8
    irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_empty |-> irq);

    // R7
    clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_STAT_CLR) |=> (!ovf_q && !udf_q));

endmodule

// File: rtl/mbox_fifo_pair.sv
module mbox_fifo_pair
    import mbox_pkg::*;
#(
    parameter int         DEPTH    = 8,
    parameter int         ADDR_W   = 8,
    parameter logic [7:0] STAT_OFS = 8'h50,
    parameter logic [7:0] PUSH_OFS = 8'h54,
    parameter logic [7:0] POP_OFS  = 8'h58
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_sel,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [31:0]       a_wdata,
    output logic [31:0]       a_rdata,
    output logic              a_irq,
    input  logic              b_sel,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [31:0]       b_wdata,
    output logic [31:0]       b_rdata,
    output logic              b_irq
);

    localparam int NPORT = 2;

    logic              sel_v   [NPORT];
    logic              wr_v    [NPORT];
    logic [ADDR_W-1:0] addr_v  [NPORT];
    logic [WORD_W-1:0] wdata_v [NPORT];
    logic [WORD_W-1:0] rdata_v [NPORT];
    logic              irq_v   [NPORT];
    logic              push_v  [NPORT];
    logic              pop_v   [NPORT];
    logic [WORD_W-1:0] pdata_v [NPORT];
    logic [WORD_W-1:0] head_v  [NPORT];
    logic              empty_v [NPORT];
    logic              full_v  [NPORT];

    assign sel_v[0]   = a_sel;
    assign wr_v[0]    = a_wr;
    assign addr_v[0]  = a_addr;
    assign wdata_v[0] = a_wdata;
    assign sel_v[1]   = b_sel;
    assign wr_v[1]    = b_wr;
    assign addr_v[1]  = b_addr;
    assign wdata_v[1] = b_wdata;
    assign a_rdata    = rdata_v[0];
    assign a_irq      = irq_v[0];
    assign b_rdata    = rdata_v[1];
    assign b_irq      = irq_v[1];

    // queue g carries words pushed by port g toward the other port
    for (genvar g = 0; g < NPORT; g++) begin : g_dir
        localparam int OTHER = NPORT - 1 - g;

        mbox_queue #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_queue (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (push_v[g]),
            .push_data(pdata_v[g]),
            .pop      (pop_v[OTHER]),
            .head     (head_v[g]),
            .empty    (empty_v[g]),
            .full     (full_v[g])
        );

        mbox_port #(
            .ADDR_W  (ADDR_W),
            .STAT_OFS(STAT_OFS),
            .PUSH_OFS(PUSH_OFS),
            .POP_OFS (POP_OFS)
        ) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (sel_v[g]),
            .wr       (wr_v[g]),
            .addr     (addr_v[g]),
            .wdata    (wdata_v[g]),
            .in_head  (head_v[OTHER]),
            .in_empty (empty_v[OTHER]),
            .out_full (full_v[g]),
            .push     (push_v[g]),
            .push_data(pdata_v[g]),
            .pop      (pop_v[g]),
            .rdata    (rdata_v[g]),
            .irq      (irq_v[g])
        );
    end

endmodule

// File: tb/mbox_fifo_pair_tb.sv
module mbox_fifo_pair_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 20000;
    localparam int VW = 78;  // {req[3:0], port, wr, addr[7:0], wdata[31:0], exp[31:0]}
    localparam int NVEC = 17;
    localparam logic [VW-1:0] VECS [NVEC] = '{
        {4'd1,  1'b0, 1'b0, 8'h50, 32'h0,        32'h0000_0002}, // R1 status after reset
        {4'd2,  1'b0, 1'b1, 8'h54, 32'hA5A5_0001, 32'h0},
        {4'd2,  1'b0, 1'b1, 8'h54, 32'hA5A5_0002, 32'h0},
        {4'd2,  1'b1, 1'b0, 8'h50, 32'h0,        32'h0000_0003}, // R2 B sees data
        {4'd3,  1'b1, 1'b0, 8'h58, 32'h0,        32'hA5A5_0001}, // R3 order
        {4'd3,  1'b1, 1'b0, 8'h58, 32'h0,        32'hA5A5_0002}, // R3
        {4'd4,  1'b1, 1'b0, 8'h50, 32'h0,        32'h0000_0002}, // R4
        {4'd2,  1'b1, 1'b1, 8'h54, 32'h5A5A_00B1, 32'h0},
        {4'd4,  1'b0, 1'b0, 8'h50, 32'h0,        32'h0000_0003}, // R4 A sees data
        {4'd3,  1'b0, 1'b0, 8'h58, 32'h0,        32'h5A5A_00B1}, // R3
        {4'd6,  1'b0, 1'b0, 8'h58, 32'h0,        32'h0},          // R6 empty pop
        {4'd6,  1'b0, 1'b0, 8'h50, 32'h0,        32'h0000_000A}, // R6 udf flag
        {4'd9,  1'b1, 1'b0, 8'h50, 32'h0,        32'h0000_0002}, // R9 B unaffected
        {4'd7,  1'b0, 1'b1, 8'h50, 32'h1234_0000, 32'h0},
        {4'd7,  1'b0, 1'b0, 8'h50, 32'h0,        32'h0000_0002}, // R7 cleared
        {4'd10, 1'b0, 1'b0, 8'h40, 32'h0,        32'h0},          // R10 unmapped read
        {4'd10, 1'b0, 1'b1, 8'h58, 32'hDEAD_BEEF, 32'h0}          // R10 write to pop
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_sel = 1'b0, a_wr = 1'b0, b_sel = 1'b0, b_wr = 1'b0;
    logic [7:0]  a_addr = '0, b_addr = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_fifo_pair u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WDOG_LIMIT) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input int p, input logic w, input logic [7:0] ad,
                          input logic [31:0] d, output logic [31:0] rd);
        @(negedge clk);
        if (p == 0) begin a_sel = 1'b1; a_wr = w; a_addr = ad; a_wdata = d; end
        else        begin b_sel = 1'b1; b_wr = w; b_addr = ad; b_wdata = d; end
        @(negedge clk);
        rd = (p == 0) ? a_rdata : b_rdata;
        a_sel = 1'b0;
        b_sel = 1'b0;
    endtask

    // A pushes d while B pops, on the same edge; returns B's read data
    task automatic push_pop(input logic [31:0] d, output logic [31:0] rd);
        @(negedge clk);
        a_sel = 1'b1; a_wr = 1'b1; a_addr = 8'h54; a_wdata = d;
        b_sel = 1'b1; b_wr = 1'b0; b_addr = 8'h58;
        @(negedge clk);
        rd = b_rdata;
        a_sel = 1'b0;
        b_sel = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R1 reset outputs
        check("R1 a_rdata", a_rdata, 32'h0);
        check("R1 b_rdata", b_rdata, 32'h0);
        check("R1 irqs", {30'h0, a_irq, b_irq}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [VW-1:0] v;
            v = VECS[i];
            access(int'(v[73]), v[72], v[71:64], v[63:32], rd);
            if (!v[72]) begin
                n_chk = n_chk + 1;
                if (rd !== v[31:0]) begin
                    n_fail = n_fail + 1;
                    $display("FAIL vector %0d R%0d actual %h expected %h",
                             i, v[77:74], rd, v[31:0]);
                end
            end
        end
        // R10: write to pop address pushed nothing toward B
        access(1, 1'b0, 8'h50, 32'h0, rd);
        check("R10 no push from unmapped write", rd, 32'h0000_0002);

        // R5 fill to depth, then overflow
        for (int i = 0; i < 8; i++) access(0, 1'b1, 8'h54, 32'hC000_0000 + i, rd);
        access(0, 1'b0, 8'h50, 32'h0, rd);
        check("R5 full clears ready", rd, 32'h0000_0000);
        access(0, 1'b1, 8'h54, 32'hBAD0_0009, rd);
        access(0, 1'b0, 8'h50, 32'h0, rd);
        check("R5 overflow flag", rd, 32'h0000_0004);
        @(negedge clk);
        check("R8 a_irq from overflow", {31'h0, a_irq}, 32'h1);
        check("R8 b_irq from data", {31'h0, b_irq}, 32'h1);
        access(1, 1'b0, 8'h50, 32'h0, rd);
        check("R9 B flags clean", rd, 32'h0000_0003);
        for (int i = 0; i < 8; i++) begin
            access(1, 1'b0, 8'h58, 32'h0, rd);
            check("R5 drained word", rd, 32'hC000_0000 + i);
        end
        access(1, 1'b0, 8'h50, 32'h0, rd);
        check("R5 dropped word absent", rd, 32'h0000_0002);
        @(negedge clk);
        check("R8 b_irq low when empty", {31'h0, b_irq}, 32'h0);
        access(0, 1'b1, 8'h50, 32'hFFFF_FFFF, rd);
        access(0, 1'b0, 8'h50, 32'h0, rd);
        check("R7 all-ones write clears", rd, 32'h0000_0002);
        @(negedge clk);
        check("R8 a_irq low after clear", {31'h0, a_irq}, 32'h0);

        // R11 simultaneous push and pop on partly filled queue
        access(0, 1'b1, 8'h54, 32'h1100_0000, rd);
        push_pop(32'h1100_0001, rd);
        check("R11 pop during push", rd, 32'h1100_0000);
        access(1, 1'b0, 8'h58, 32'h0, rd);
        check("R11 pushed word kept", rd, 32'h1100_0001);
        access(1, 1'b0, 8'h50, 32'h0, rd);
        check("R11 queue empty", rd, 32'h0000_0002);

        // R11 push into full queue with same-cycle pop is dropped
        for (int i = 0; i < 8; i++) access(0, 1'b1, 8'h54, 32'h2200_0000 + i, rd);
        push_pop(32'hDEAD_0000, rd);
        check("R11 pop from full", rd, 32'h2200_0000);
        access(0, 1'b0, 8'h50, 32'h0, rd);
        check("R11 overflow on full", rd, 32'h0000_0006);
        for (int i = 1; i < 8; i++) begin
            access(1, 1'b0, 8'h58, 32'h0, rd);
            check("R11 remaining word", rd, 32'h2200_0000 + i);
        end
        access(1, 1'b0, 8'h50, 32'h0, rd);
        check("R11 dropped push absent", rd, 32'h0000_0002);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule